// File: doc/BRIEF.md
# Trace Packet Framer and Classifier

This block sits at the front of a trace decode pipeline. It takes one trace byte per valid strobe, together with a free-running timestamp, and cuts the stream into packets. For each packet it raises a one-cycle result pulse carrying a kind code, the timestamps of the first and last byte, and, for the compact instruction-execution headers, the numbers of executed and skipped instructions. Branch-address and instruction-sync payloads are only framed here; their fields are decoded further down the pipeline.

Two mechanisms keep the framer aligned when the stream is corrupt or starts mid-packet. First, a window over the most recent five bytes spots the alignment pattern. When it sees the pattern, it overrides whatever packet is half built. Second, a long silence on the input throws away any partial packet, so the next byte is read as a header.

Top module: `trace_framer`

## Requirements
- R1: After reset `pktValid` is low and no packet is open. The first byte after reset is never treated as following an idle gap.
- R2: A header with bit 0 set opens a branch packet (kind 0). Each byte with bit 7 set continues it. The packet ends on the first byte with bit 7 clear, or on its fifth byte whatever that byte holds.
- R3: When the current byte is 0x80 and the four bytes before it were 0x00, an alignment packet (kind 8) is reported in place of any partial packet. Its start timestamp is that of the first 0x00 byte. This holds even when the 0x80 arrives after an idle gap.
- R4: A byte whose timestamp exceeds that of the previous byte by more than GAP_BYTES*BYTE_TICKS (64 by default) discards any partial packet, and the byte is then decoded as a header. A difference of exactly the limit does not discard.
- R5: A header with (byte & 0x83) == 0x80 is a one-byte execution packet of kind 1. `execCount` is bits [5:2], `skipCount` is bit 6, and `execPair` is 0.
- R6: A header with (byte & 0xF3) == 0x82 is a one-byte execution packet of kind 2. Bit 3 describes the first instruction and bit 2 the second, and a set bit means skipped. `execPair[1]` and `execPair[0]` are 1 for an executed first and second instruction respectively, and the two counts sum to 2.
- R7: Header 0x08 opens an instruction-sync packet (kind 3) of exactly six bytes.
- R8: Header 0x70 opens an instruction-sync packet with cycle count (kind 4). It is followed by a cycle-count field that ends on a byte with bit 7 clear or after five bytes, then five more bytes.
- R9: The headers 0x0C, 0x76 and 0x7E are one-byte packets of kinds 5, 6 and 7. Any other header, including an execution-style byte that matches neither format, is a one-byte packet of kind 9.
- R10: `pktValid` pulses in the cycle after the last byte of a packet is accepted. `pktStartTs` and `pktEndTs` hold the timestamps of the packet's first and last byte.
- R11: Header 0x00 opens an alignment run that absorbs further 0x00 bytes. A non-zero byte that does not complete the pattern discards the run and is decoded as a header.
- R12: Every packet whose kind is not 1 or 2 reports zero in `execCount`, `skipCount` and `execPair`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A trace byte is present this cycle |
| byteData | input | 8 | Trace byte |
| timeNow | input | TS_W | Free-running timestamp |
| pktValid | output | 1 | One-cycle pulse: a packet has been completed |
| pktKind | output | 4 | Packet kind code (see requirements) |
| pktStartTs | output | TS_W | Timestamp of the packet's first byte |
| pktEndTs | output | TS_W | Timestamp of the packet's last byte |
| execCount | output | 4 | Executed instructions (kinds 1 and 2) |
| skipCount | output | 2 | Skipped instructions (kinds 1 and 2) |
| execPair | output | 2 | Per-instruction executed flags (kind 2) |

## Verification
The idle-gap discard and the alignment override can both act on the same byte. This happens when four 0x00 bytes are sent, the input is held quiet for longer than the gap limit, and 0x80 follows. The expected outcome is a single alignment packet whose start timestamp is that of the first 0x00, which shows that the window survives the gap and that the override wins. The override is also hit on the byte that would otherwise complete a six-byte instruction-sync packet, and the gap limit is probed one tick on either side.

// File: rtl/trace_framer_pkg.sv
package trace_framer_pkg;

  localparam int SYNC_LEN = 5;
  localparam logic [7:0] SYNC_LAST = 8'h80;

  typedef enum logic [3:0] {
    KIND_BRANCH    = 4'd0,
    KIND_EXEC_FMT1 = 4'd1,
    KIND_EXEC_FMT2 = 4'd2,
    KIND_ISYNC     = 4'd3,
    KIND_ISYNC_CYC = 4'd4,
    KIND_TRIGGER   = 4'd5,
    KIND_EXC_EXIT  = 4'd6,
    KIND_EXC_ENTRY = 4'd7,
    KIND_ALIGN     = 4'd8,
    KIND_UNKNOWN   = 4'd9
  } pktKind_e;

  typedef enum logic [2:0] {
    HDR_BRANCH,
    HDR_ZERO,
    HDR_ISYNC,
    HDR_ISYNC_CYC,
    HDR_SINGLE
  } hdrClass_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     latchStart;  // remember timeNow as packet start
    logic     emit;        // packet completes with this byte
    logic     startNow;    // one-byte packet: start is this byte
    logic     startWin;    // alignment: start from the byte window
    pktKind_e kind;
  } frameStrobe_t;

  typedef struct packed {
    logic [3:0] exec;
    logic [1:0] skip;
    logic [1:0] pair;
  } execInfo_t;

  function automatic hdrClass_e classifyHeader(input logic [7:0] b);
    if (b[0])              return HDR_BRANCH;
    else if (b == 8'h00)   return HDR_ZERO;
    else if (b == 8'h08)   return HDR_ISYNC;
    else if (b == 8'h70)   return HDR_ISYNC_CYC;
    else                   return HDR_SINGLE;
  endfunction

  function automatic pktKind_e classifySingle(input logic [7:0] b);
    if (b == 8'h0C)                   return KIND_TRIGGER;
    else if (b == 8'h76)              return KIND_EXC_EXIT;
    else if (b == 8'h7E)              return KIND_EXC_ENTRY;
    else if ((b & 8'h83) == 8'h80)    return KIND_EXEC_FMT1;
    else if ((b & 8'hF3) == 8'h82)    return KIND_EXEC_FMT2;
    else                              return KIND_UNKNOWN;
  endfunction

  function automatic execInfo_t decodeExec(input logic [7:0] b, input pktKind_e k);
    execInfo_t r;
    logic [1:0] ran;
    r = '0;
    if (k == KIND_EXEC_FMT1) begin
      r.exec = b[5:2];
      r.skip = {1'b0, b[6]};
    end else if (k == KIND_EXEC_FMT2) begin
      r.pair = {~b[3], ~b[2]};
      ran    = {1'b0, r.pair[1]} + {1'b0, r.pair[0]};
      r.exec = {2'b00, ran};
      r.skip = 2'd2 - ran;
    end
    return r;
  endfunction

endpackage

// File: rtl/tfr_ctrl.sv
module tfr_ctrl
  import trace_framer_pkg::*;
#(
  parameter int BR_MAX_LEN  = 5,
  parameter int CYC_MAX_LEN = 5,
  parameter int ISYNC_TAIL  = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         byteValid,
  input  logic [7:0]   byteData,
  input  logic         gapHit,
  input  logic         syncHit,
  output frameStrobe_t strobe
);

  localparam int MAX_A   = (BR_MAX_LEN > CYC_MAX_LEN) ? BR_MAX_LEN : CYC_MAX_LEN;
  localparam int MAX_LEN = (MAX_A > ISYNC_TAIL) ? MAX_A : ISYNC_TAIL;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] BR_LAST  = CNT_W'(BR_MAX_LEN - 1);
  localparam logic [CNT_W-1:0] CYC_LAST = CNT_W'(CYC_MAX_LEN - 1);
  localparam logic [CNT_W-1:0] TAIL_LEN = CNT_W'(ISYNC_TAIL);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRANCH,
    ST_CYC,
    ST_TAIL,
    ST_ZRUN
  } frameState_e;

  frameState_e state, stateNext, stEff;
  logic [CNT_W-1:0] cnt, cntNext;
  pktKind_e tailKind, tailKindNext;
  logic hdrMode;

  always_comb begin
    strobe       = '0;
    strobe.kind  = KIND_UNKNOWN;
    stateNext    = state;
    cntNext      = cnt;
    tailKindNext = tailKind;
    // An idle gap makes the byte look like it arrived with nothing open
    stEff   = gapHit ? ST_IDLE : state;
    hdrMode = (stEff == ST_IDLE) || (stEff == ST_ZRUN && byteData != 8'h00);

    if (byteValid) begin
      if (syncHit) begin
        strobe.emit     = 1'b1;
        strobe.startWin = 1'b1;
        strobe.kind     = KIND_ALIGN;
        stateNext       = ST_IDLE;
      end else if (hdrMode) begin
        unique case (classifyHeader(byteData))
          HDR_BRANCH: begin
            if (!byteData[7]) begin
              strobe.emit     = 1'b1;
              strobe.startNow = 1'b1;
              strobe.kind     = KIND_BRANCH;
              stateNext       = ST_IDLE;
            end else begin
              strobe.latchStart = 1'b1;
              stateNext         = ST_BRANCH;
              cntNext           = CNT_W'(1);
            end
          end
          HDR_ZERO: begin
            strobe.latchStart = 1'b1;
            stateNext         = ST_ZRUN;
          end
          HDR_ISYNC: begin
            strobe.latchStart = 1'b1;
            stateNext         = ST_TAIL;
            cntNext           = TAIL_LEN;
            tailKindNext      = KIND_ISYNC;
          end
          HDR_ISYNC_CYC: begin
            strobe.latchStart = 1'b1;
            stateNext         = ST_CYC;
            cntNext           = '0;
          end
          default: begin
            strobe.emit     = 1'b1;
            strobe.startNow = 1'b1;
            strobe.kind     = classifySingle(byteData);
            stateNext       = ST_IDLE;
          end
        endcase
      end else begin
        unique case (stEff)
          ST_BRANCH: begin
            if (!byteData[7] || cnt == BR_LAST) begin
              strobe.emit = 1'b1;
              strobe.kind = KIND_BRANCH;
              stateNext   = ST_IDLE;
            end else begin
              cntNext = cnt + 1'b1;
            end
          end
          ST_CYC: begin
            if (!byteData[7] || cnt == CYC_LAST) begin
              stateNext    = ST_TAIL;
              cntNext      = TAIL_LEN;
              tailKindNext = KIND_ISYNC_CYC;
            end else begin
              cntNext = cnt + 1'b1;
            end
          end
          ST_TAIL: begin
            if (cnt == CNT_W'(1)) begin
              strobe.emit = 1'b1;
              strobe.kind = tailKind;
              stateNext   = ST_IDLE;
            end else begin
              cntNext = cnt - 1'b1;
            end
          end
          default: ;  // zero run absorbing another 0x00
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      tailKind <= KIND_ISYNC;
    end else begin
      state    <= stateNext;
      cnt      <= cntNext;
      tailKind <= tailKindNext;
    end
  end

  AST_BRANCH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_BRANCH |-> (cnt >= CNT_W'(1) && cnt <= BR_LAST)); // R2
  AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_CYC |-> cnt <= CYC_LAST); // R8
  AST_TAIL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_TAIL |-> (cnt >= CNT_W'(1) && cnt <= TAIL_LEN)); // R7
  AST_IDLE_AFTER_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |=> (state == ST_IDLE)); // R10

endmodule

// File: rtl/tfr_datapath.sv
module tfr_datapath
  import trace_framer_pkg::*;
#(
  parameter int TS_W      = 32,
  parameter int GAP_TICKS = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            byteValid,
  input  logic [7:0]      byteData,
  input  logic [TS_W-1:0] timeNow,
  input  frameStrobe_t    strobe,
  output logic            gapHit,
  output logic            syncHit,
  output logic            pktValid,
  output pktKind_e        pktKind,
  output logic [TS_W-1:0] pktStartTs,
  output logic [TS_W-1:0] pktEndTs,
  output logic [3:0]      execCount,
  output logic [1:0]      skipCount,
  output logic [1:0]      execPair
);

  localparam int HIST = SYNC_LEN - 1;
  localparam logic [TS_W-1:0] GAP_LIMIT = TS_W'(GAP_TICKS);

  logic [7:0]      byteWin [HIST];
  logic [TS_W-1:0] tsWin   [HIST];
  logic [TS_W-1:0] lastTs, startReg;
  logic            haveLast;
  logic            priorZero;
  execInfo_t       execInfo;

  always_comb begin
    priorZero = 1'b1;
    for (int i = 0; i < HIST; i++) priorZero &= (byteWin[i] == 8'h00);
  end

  assign syncHit  = byteValid && priorZero && (byteData == SYNC_LAST);
  assign gapHit   = byteValid && haveLast && ((timeNow - lastTs) > GAP_LIMIT);
  assign execInfo = decodeExec(byteData, strobe.kind);

  // Byte/timestamp history and gap reference
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < HIST; i++) begin
        byteWin[i] <= 8'hFF;
        tsWin[i]   <= '0;
      end
      lastTs   <= '0;
      haveLast <= 1'b0;
    end else if (byteValid) begin
      byteWin[0] <= byteData;
      tsWin[0]   <= timeNow;
      for (int i = 1; i < HIST; i++) begin
        byteWin[i] <= byteWin[i-1];
        tsWin[i]   <= tsWin[i-1];
      end
      lastTs   <= timeNow;
      haveLast <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) startReg <= '0;
    else if (strobe.latchStart) startReg <= timeNow;
  end

  // Result register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktValid   <= 1'b0;
      pktKind    <= KIND_BRANCH;
      pktStartTs <= '0;
      pktEndTs   <= '0;
      execCount  <= '0;
      skipCount  <= '0;
      execPair   <= '0;
    end else begin
      pktValid <= strobe.emit;
      if (strobe.emit) begin
        pktKind    <= strobe.kind;
        pktStartTs <= strobe.startNow ? timeNow :
                      strobe.startWin ? tsWin[HIST-1] : startReg;
        pktEndTs   <= timeNow;
        execCount  <= execInfo.exec;
        skipCount  <= execInfo.skip;
        execPair   <= execInfo.pair;
      end
    end
  end

  AST_PKT_FROM_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> $past(byteValid)); // R10
  AST_END_TS: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> pktEndTs == $past(timeNow)); // R10
  AST_SYNC_WINS: assert property (@(posedge clk) disable iff (!rstN)
    syncHit |=> (pktValid && pktKind == KIND_ALIGN)); // R3
  AST_FMT1_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktKind == KIND_EXEC_FMT1) |-> (skipCount <= 2'd1 && execPair == 2'b00)); // R5
  AST_FMT2_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktKind == KIND_EXEC_FMT2) |-> (int'(execCount) + int'(skipCount) == 2)); // R6
  AST_NONEXEC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktKind != KIND_EXEC_FMT1 && pktKind != KIND_EXEC_FMT2)
      |-> (execCount == 4'd0 && skipCount == 2'd0 && execPair == 2'b00)); // R12

endmodule

// File: rtl/trace_framer.sv
module trace_framer
  import trace_framer_pkg::*;
#(
  parameter int TS_W        = 32,
  parameter int BYTE_TICKS  = 4,
  parameter int GAP_BYTES   = 16,
  parameter int BR_MAX_LEN  = 5,
  parameter int CYC_MAX_LEN = 5,
  parameter int ISYNC_TAIL  = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            byteValid,
  input  logic [7:0]      byteData,
  input  logic [TS_W-1:0] timeNow,
  output logic            pktValid,
  output logic [3:0]      pktKind,
  output logic [TS_W-1:0] pktStartTs,
  output logic [TS_W-1:0] pktEndTs,
  output logic [3:0]      execCount,
  output logic [1:0]      skipCount,
  output logic [1:0]      execPair
);

  localparam int GAP_TICKS = BYTE_TICKS * GAP_BYTES;

  frameStrobe_t strobe;
  logic         gapHit, syncHit;
  pktKind_e     kindInt;

  tfr_ctrl #(
    .BR_MAX_LEN (BR_MAX_LEN),
    .CYC_MAX_LEN(CYC_MAX_LEN),
    .ISYNC_TAIL (ISYNC_TAIL)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .byteValid(byteValid),
    .byteData (byteData),
    .gapHit   (gapHit),
    .syncHit  (syncHit),
    .strobe   (strobe)
  );

  tfr_datapath #(
    .TS_W     (TS_W),
    .GAP_TICKS(GAP_TICKS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .byteData  (byteData),
    .timeNow   (timeNow),
    .strobe    (strobe),
    .gapHit    (gapHit),
    .syncHit   (syncHit),
    .pktValid  (pktValid),
    .pktKind   (kindInt),
    .pktStartTs(pktStartTs),
    .pktEndTs  (pktEndTs),
    .execCount (execCount),
    .skipCount (skipCount),
    .execPair  (execPair)
  );

  assign pktKind = kindInt;

endmodule

// File: tb/trace_framer_tb.sv
module trace_framer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TS_W = 32;

  localparam logic [3:0] K_BRANCH = 4'd0, K_FMT1 = 4'd1, K_FMT2 = 4'd2,
                         K_ISYNC = 4'd3, K_ISYNC_CYC = 4'd4, K_TRIG = 4'd5,
                         K_EXIT = 4'd6, K_ENTRY = 4'd7, K_ALIGN = 4'd8, K_UNK = 4'd9;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            byteValid = 1'b0;
  logic [7:0]      byteData = 8'h00;
  logic [TS_W-1:0] timeNow = '0;
  logic            pktValid;
  logic [3:0]      pktKind;
  logic [TS_W-1:0] pktStartTs, pktEndTs;
  logic [3:0]      execCount;
  logic [1:0]      skipCount, execPair;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0]      kind;
    logic [TS_W-1:0] startTs;
    logic [TS_W-1:0] endTs;
    logic [3:0]      exec;
    logic [1:0]      skip;
    logic [1:0]      pair;
    string           tag;
  } expItem_t;

  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) timeNow <= timeNow + 1'b1;

  trace_framer u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .timeNow(timeNow), .pktValid(pktValid), .pktKind(pktKind),
    .pktStartTs(pktStartTs), .pktEndTs(pktEndTs), .execCount(execCount),
    .skipCount(skipCount), .execPair(execPair)
  );

  task automatic sendByte(input logic [7:0] d, input int idle, output logic [TS_W-1:0] ts);
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      byteValid = 1'b0;
    end
    @(negedge clk);
    byteValid = 1'b1;
    byteData  = d;
    ts        = timeNow;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteValid = 1'b0;
    end
  endtask

  task automatic pushExp(input logic [3:0] k, input logic [TS_W-1:0] s, input logic [TS_W-1:0] e,
                         input logic [3:0] ex, input logic [1:0] sk, input logic [1:0] pr,
                         input string tag);
    expItem_t it;
    it.kind = k; it.startTs = s; it.endTs = e;
    it.exec = ex; it.skip = sk; it.pair = pr; it.tag = tag;
    expQ.push_back(it);
  endtask

  // One-byte packet helper
  task automatic single(input logic [7:0] d, input logic [3:0] k, input logic [3:0] ex,
                        input logic [1:0] sk, input logic [1:0] pr, input string tag);
    logic [TS_W-1:0] t;
    sendByte(d, 0, t);
    pushExp(k, t, t, ex, sk, pr, tag);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && pktValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected packet kind=%0d start=%0d end=%0d, expected none",
                 pktKind, pktStartTs, pktEndTs);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (pktKind !== e.kind || pktStartTs !== e.startTs || pktEndTs !== e.endTs ||
            execCount !== e.exec || skipCount !== e.skip || execPair !== e.pair) begin
          errors++;
          $display("FAIL %s actual kind=%0d start=%0d end=%0d exec=%0d skip=%0d pair=%b expected kind=%0d start=%0d end=%0d exec=%0d skip=%0d pair=%b",
                   e.tag, pktKind, pktStartTs, pktEndTs, execCount, skipCount, execPair,
                   e.kind, e.startTs, e.endTs, e.exec, e.skip, e.pair);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [TS_W-1:0] t0, t1, t2, t3, t4, t5;
    logic [TS_W-1:0] tIgn;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (pktValid !== 1'b0) begin
        errors++;
        $display("FAIL R1 pktValid after reset actual %b expected 0", pktValid);
      end
    end

    // R1: first byte after a long quiet start is not a gap
    sendByte(8'h81, 100, t0);
    sendByte(8'h02, 0, t1);
    pushExp(K_BRANCH, t0, t1, 0, 0, 0, "R1");

    // R2: branch forms
    single(8'h01, K_BRANCH, 0, 0, 0, "R2");
    sendByte(8'h81, 0, t0); sendByte(8'h85, 0, tIgn); sendByte(8'h03, 0, t1);
    pushExp(K_BRANCH, t0, t1, 0, 0, 0, "R2");
    sendByte(8'h81, 0, t0); sendByte(8'h80, 0, tIgn); sendByte(8'h80, 0, tIgn);
    sendByte(8'h80, 0, tIgn); sendByte(8'hC0, 0, t1);
    pushExp(K_BRANCH, t0, t1, 0, 0, 0, "R2");
    single(8'h0C, K_TRIG, 0, 0, 0, "R2");

    // R5: execution format 1
    single(8'hBC, K_FMT1, 4'd15, 2'd0, 2'b00, "R5");
    single(8'hC4, K_FMT1, 4'd1, 2'd1, 2'b00, "R5");
    single(8'h80, K_FMT1, 4'd0, 2'd0, 2'b00, "R5");

    // R6: execution format 2
    single(8'h8A, K_FMT2, 4'd1, 2'd1, 2'b01, "R6");
    single(8'h82, K_FMT2, 4'd2, 2'd0, 2'b11, "R6");
    single(8'h8E, K_FMT2, 4'd0, 2'd2, 2'b00, "R6");
    single(8'h86, K_FMT2, 4'd1, 2'd1, 2'b10, "R6");

    // R7: instruction sync, no cycle count
    sendByte(8'h08, 0, t0);
    sendByte(8'h11, 0, tIgn); sendByte(8'h22, 0, tIgn); sendByte(8'h33, 0, tIgn);
    sendByte(8'h44, 0, tIgn); sendByte(8'h55, 0, t1);
    pushExp(K_ISYNC, t0, t1, 0, 0, 0, "R7");

    // R8: instruction sync with cycle count, short and capped
    sendByte(8'h70, 0, t0); sendByte(8'h85, 0, tIgn); sendByte(8'h01, 0, tIgn);
    for (int i = 0; i < 5; i++) sendByte(8'h10 + 8'(i), 0, t1);
    pushExp(K_ISYNC_CYC, t0, t1, 0, 0, 0, "R8");
    sendByte(8'h70, 0, t0);
    for (int i = 0; i < 5; i++) sendByte(8'hFF, 0, tIgn);
    for (int i = 0; i < 5; i++) sendByte(8'h20 + 8'(i), 0, t1);
    pushExp(K_ISYNC_CYC, t0, t1, 0, 0, 0, "R8");

    // R9: single-byte kinds
    single(8'h0C, K_TRIG, 0, 0, 0, "R9");
    single(8'h76, K_EXIT, 0, 0, 0, "R9");
    single(8'h7E, K_ENTRY, 0, 0, 0, "R9");
    single(8'h04, K_UNK, 0, 0, 0, "R9");
    single(8'hC2, K_UNK, 0, 0, 0, "R9");

    // R11: zero run broken by a header
    sendByte(8'h00, 0, tIgn); sendByte(8'h00, 0, tIgn);
    single(8'h0C, K_TRIG, 0, 0, 0, "R11");

    // R3: plain alignment pattern
    sendByte(8'h00, 0, t0); sendByte(8'h00, 0, tIgn); sendByte(8'h00, 0, tIgn);
    sendByte(8'h00, 0, tIgn); sendByte(8'h80, 0, t1);
    pushExp(K_ALIGN, t0, t1, 0, 0, 0, "R3");

    // R3: alignment overrides a partial instruction sync
    sendByte(8'h08, 0, tIgn);
    sendByte(8'h00, 0, t0); sendByte(8'h00, 0, tIgn); sendByte(8'h00, 0, tIgn);
    sendByte(8'h00, 0, tIgn); sendByte(8'h80, 0, t1);
    pushExp(K_ALIGN, t0, t1, 0, 0, 0, "R3");

    // R4: gap just over the limit discards partial branch
    sendByte(8'h81, 0, tIgn);
    sendByte(8'h0C, 64, t1);
    pushExp(K_TRIG, t1, t1, 0, 0, 0, "R4");
    // R4: gap exactly at the limit keeps the partial branch
    sendByte(8'h81, 0, t0);
    sendByte(8'h05, 63, t1);
    pushExp(K_BRANCH, t0, t1, 0, 0, 0, "R4");
    // R4: gap discards partial instruction sync
    sendByte(8'h08, 0, tIgn); sendByte(8'h11, 0, tIgn);
    sendByte(8'h76, 80, t1);
    pushExp(K_EXIT, t1, t1, 0, 0, 0, "R4");

    // R3 with R4 in the same cycle: gap before the final 0x80
    sendByte(8'h00, 0, t0); sendByte(8'h00, 0, tIgn); sendByte(8'h00, 0, tIgn);
    sendByte(8'h00, 0, tIgn);
    sendByte(8'h80, 100, t1);
    pushExp(K_ALIGN, t0, t1, 0, 0, 0, "R3");

    // R12 is covered by every non-execution comparison above
    quiet(6);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R10 missing packets actual %0d outstanding expected 0", expQ.size());
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule